// File: doc/BRIEF.md
# Hamming SEC-DED Protected Word Store

This block keeps sixteen 8-bit words in an internal array and guards each one with a Hamming code plus an overall parity bit. When a word is written, four check bits are derived from the data. They are interleaved with the data into a 12-bit codeword, and a thirteenth bit is added that makes the parity of the whole stored word even. When a word is read, the check bits are recomputed and XORed with the stored ones to form a syndrome. The block then decides between a clean word, a correctable single error and an uncorrectable multi-bit error, and it returns repaired data where it can.

The 4-bit syndrome, weighted C8 C4 C2 C1 from most to least significant, gives directly the 1-based codeword position of a single flipped bit. The overall parity bit tells an odd number of flips (correctable) apart from an even number (detected only). A test port XORs a chosen mask into any stored word so that every fault class can be produced on purpose. Corrections are applied only to the read result and are never written back into the array.

Top module: `secded_mem_guard`

## Requirements
- R1: A stored word is 13 bits. Bit i-1 holds codeword position i for i = 1..12, and bit 12 holds the overall parity. Check bits C1, C2, C4 and C8 sit at positions 1, 2, 4 and 8. Data bits wr_data_i[0..7] (D1..D8) fill positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order. Check bit Ck is the XOR of the data bits whose position has the bit of weight k set. The parity bit makes the XOR of all 13 bits zero.
- R2: A read with a zero syndrome and even overall parity returns the stored data with corrected_o and uncorrectable_o both low.
- R3: A single flipped data bit gives a syndrome equal to its position. The read returns the original data with corrected_o high.
- R4: A single flipped check bit (syndrome 1, 2, 4 or 8 with parity failing) returns the stored data bits unchanged with corrected_o high.
- R5: A flipped overall parity bit alone (zero syndrome, parity failing) returns the data unchanged with corrected_o high.
- R6: A non-zero syndrome with even overall parity (a double error) sets uncorrectable_o, clears corrected_o and returns the raw stored data bits. corrected_o and uncorrectable_o are never high together.
- R7: A syndrome greater than 12 sets uncorrectable_o and returns the raw stored data bits, whatever the parity.
- R8: Read data and flags are registered. rd_valid_o is high exactly in the cycle after a cycle with rd_en_i high. In any other cycle, rd_data_o, corrected_o and uncorrectable_o hold their last values.
- R9: With inj_en_i high, inj_mask_i (in the R1 layout) is XORed into the word at inj_addr_i. A write to the same address in the same cycle takes priority and the mask is dropped. A corrected read does not repair the stored word.
- R10: Reset clears every stored word to zero, which is a valid codeword, and clears rd_valid_o, rd_data_o and both flags.
- R11: A read of an address that is written in the same cycle returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 4 | Read address |
| inj_en_i | input | 1 | Fault-injection strobe |
| inj_addr_i | input | 4 | Fault-injection address |
| inj_mask_i | input | 13 | Bits to flip in the stored word |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 8 | Corrected read data |
| corrected_o | output | 1 | A single error was repaired |
| uncorrectable_o | output | 1 | A multi-bit error was detected |

## Verification
On every cycle, the assertions check the following: encoded words have even parity, the two flags are never high together, the outputs stay stable between reads, clean and check-bit-only syndromes produce the right flags and data, and syndromes above 12 are always flagged as uncorrectable. Only the bench's scenarios can show the rest. It builds each fault class by injection and compares the data against values computed from the bit layout: data-bit, check-bit and parity-bit singles, doubles, and a triple that aliases beyond position 12. It also covers write-over-injection priority, read-before-write ordering and the absence of write-back.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;
  localparam int CW_W   = DATA_W + CHK_W;
  localparam int WORD_W = CW_W + 1;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CHK_W-1:0]  syn_t;
  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic logic is_pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // scatter data bits into the non-power-of-two positions
  function automatic cw_t place_data(data_t d);
    cw_t cw;
    int  j;
    cw = '0;
    j  = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_pow2(p)) begin
        cw[p-1] = d[j];
        j++;
      end
    end
    return cw;
  endfunction

  function automatic data_t pick_data(cw_t cw);
    data_t d;
    int    j;
    d = '0;
    j = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_pow2(p)) begin
        d[j] = cw[p-1];
        j++;
      end
    end
    return d;
  endfunction

  // parity over data positions only, one bit per position weight
  function automatic syn_t calc_chk(cw_t cw);
    syn_t c;
    c = '0;
    for (int k = 0; k < CHK_W; k++) begin
      for (int p = 1; p <= CW_W; p++) begin
        if (!is_pow2(p) && p[k]) c[k] = c[k] ^ cw[p-1];
      end
    end
    return c;
  endfunction

  function automatic syn_t stored_chk(cw_t cw);
    syn_t c;
    for (int k = 0; k < CHK_W; k++) c[k] = cw[(1 << k) - 1];
    return c;
  endfunction
endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
(
  input  data_t data_i,
  output word_t word_o
);
  cw_t  cw;
  syn_t chk;

  always_comb begin
    cw  = place_data(data_i);
    chk = calc_chk(cw);
    for (int k = 0; k < CHK_W; k++) cw[(1 << k) - 1] = chk[k];
  end

  assign word_o = {^cw, cw};
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
  import secded_pkg::*;
(
  input  word_t word_i,
  output data_t data_o,
  output data_t raw_data_o,
  output syn_t  syn_o,
  output logic  par_err_o,
  output logic  corr_o,
  output logic  unc_o
);
  cw_t  cw, flip, fixed;
  syn_t syn;
  logic par_err, in_range;

  assign cw       = word_i[CW_W-1:0];
  assign syn      = stored_chk(cw) ^ calc_chk(cw);
  assign par_err  = ^word_i;
  assign in_range = syn <= syn_t'(CW_W);

  always_comb begin
    for (int p = 1; p <= CW_W; p++) flip[p-1] = (syn == syn_t'(p));
  end

  always_comb begin
    corr_o = 1'b0;
    unc_o  = 1'b0;
    fixed  = cw;
    if (syn == '0) begin
      corr_o = par_err;            // only the parity bit flipped
    end else if (!par_err || !in_range) begin
      unc_o  = 1'b1;
    end else begin
      fixed  = cw ^ flip;
      corr_o = 1'b1;
    end
  end

  assign data_o     = pick_data(fixed);
  assign raw_data_o = pick_data(cw);
  assign syn_o      = syn;
  assign par_err_o  = par_err;
endmodule

// File: rtl/secded_store.sv
module secded_store
  import secded_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  word_t             wword_i,
  input  logic              inj_en_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  word_t             inj_mask_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output word_t             rword_o
);
  word_t mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[i] <= '0;
      else if (we_i && waddr_i == IDX)         mem_q[i] <= wword_i;
      else if (inj_en_i && inj_addr_i == IDX)  mem_q[i] <= mem_q[i] ^ inj_mask_i;
    end
  end

  assign rword_o = mem_q[raddr_i];
endmodule

// File: rtl/secded_mem_guard.sv
module secded_mem_guard
  import secded_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              inj_en_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  logic [WORD_W-1:0] inj_mask_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              corrected_o,
  output logic              uncorrectable_o
);
  word_t enc_word, rd_word;
  data_t dec_data, raw_data;
  syn_t  dec_syn;
  logic  dec_par_err, dec_corr, dec_unc;

  secded_encoder u_enc (.data_i(wr_data_i), .word_o(enc_word));

  secded_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk_i, .rst_ni,
    .we_i(wr_en_i), .waddr_i(wr_addr_i), .wword_i(enc_word),
    .inj_en_i, .inj_addr_i, .inj_mask_i,
    .raddr_i(rd_addr_i), .rword_o(rd_word)
  );

  secded_decoder u_dec (
    .word_i(rd_word), .data_o(dec_data), .raw_data_o(raw_data),
    .syn_o(dec_syn), .par_err_o(dec_par_err),
    .corr_o(dec_corr), .unc_o(dec_unc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o      <= 1'b0;
      rd_data_o       <= '0;
      corrected_o     <= 1'b0;
      uncorrectable_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) begin
        rd_data_o       <= dec_data;
        corrected_o     <= dec_corr;
        uncorrectable_o <= dec_unc;
      end
    end
  end

  // R1
  enc_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (^enc_word) == 1'b0);

  // R6
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(corrected_o && uncorrectable_o));

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> $stable({rd_data_o, corrected_o, uncorrectable_o}));

  // R2
  clean_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && dec_syn == '0 && !dec_par_err
    |=> !corrected_o && !uncorrectable_o && rd_data_o == $past(raw_data));

  // R4
  chk_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && dec_par_err && $countones(dec_syn) == 1
    |=> corrected_o && rd_data_o == $past(raw_data));

  // R7
  syn_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && dec_syn > syn_t'(CW_W)
    |=> uncorrectable_o && rd_data_o == $past(raw_data));
endmodule

// File: tb/secded_mem_guard_bench.sv
module secded_mem_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, inj_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0, inj_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [12:0] inj_mask = '0;
  logic        rd_valid, corrected, uncorr;
  logic [7:0]  rd_data;

  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secded_mem_guard u_secded_mem_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .inj_en_i(inj_en), .inj_addr_i(inj_addr), .inj_mask_i(inj_mask),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .corrected_o(corrected), .uncorrectable_o(uncorr)
  );

  // {data, mask, exp_corrected, exp_uncorrectable}
  localparam logic [22:0] VEC [NVEC] = '{
    {8'hA5, 13'h0000, 1'b0, 1'b0},  // R2 clean
    {8'hA5, 13'h0004, 1'b1, 1'b0},  // R3 pos3 (D1)
    {8'h3C, 13'h0800, 1'b1, 1'b0},  // R3 pos12 (D8)
    {8'h3C, 13'h0001, 1'b1, 1'b0},  // R4 pos1 (C1)
    {8'hFF, 13'h0080, 1'b1, 1'b0},  // R4 pos8 (C8)
    {8'h00, 13'h1000, 1'b1, 1'b0},  // R5 parity bit
    {8'h5A, 13'h0014, 1'b0, 1'b1},  // R6 D1+D2
    {8'h96, 13'h0003, 1'b0, 1'b1},  // R6 C1+C2
    {8'hC3, 13'h1020, 1'b0, 1'b1},  // R6 parity+D3
    {8'h71, 13'h0803, 1'b0, 1'b1},  // R7 syndrome 15
    {8'h00, 13'h0040, 1'b1, 1'b0},  // R3 pos7 (D4)
    {8'hFF, 13'h0000, 1'b0, 1'b0}   // R2 clean
  };

  // raw data bits after a mask, from the R1 layout
  function automatic logic [7:0] flip_data(logic [7:0] d, logic [12:0] m);
    return d ^ {m[11], m[10], m[9], m[8], m[6], m[5], m[4], m[2]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [3:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_inject(logic [3:0] a, logic [12:0] m);
    inj_en = 1'b1; inj_addr = a; inj_mask = m;
    @(negedge clk);
    inj_en = 1'b0; inj_mask = '0;
  endtask

  task automatic do_read(logic [3:0] a);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 valid after reset", rd_valid, 0);
    chk("R10 data after reset", {rd_data, corrected, uncorr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(4'd15);
    chk("R10 cleared word reads clean", {rd_valid, rd_data, corrected, uncorr}, {1'b1, 8'h00, 2'b00});

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0]  d;
      logic [12:0] m;
      logic        ec, eu;
      logic [7:0]  ed;
      {d, m, ec, eu} = VEC[i];
      ed = eu ? flip_data(d, m) : d;
      do_write(4'(i), d);
      if (m != '0) do_inject(4'(i), m);
      do_read(4'(i));
      chk($sformatf("R2-R7 vec%0d valid", i), rd_valid, 1);
      chk($sformatf("R3/R4/R5/R6/R7 vec%0d data", i), rd_data, ed);
      chk($sformatf("R3/R4/R5 vec%0d corrected", i), corrected, ec);
      chk($sformatf("R6/R7 vec%0d uncorrectable", i), uncorr, eu);
    end

    // R8: no read -> valid low, outputs held
    @(negedge clk);
    chk("R8 valid low without read", rd_valid, 0);
    chk("R8 outputs held", {rd_data, corrected, uncorr}, {8'hFF, 2'b00});

    // R9: no write-back of correction
    do_read(4'd1);
    chk("R9 still corrected on reread", {rd_data, corrected, uncorr}, {8'hA5, 2'b10});

    // R9: write wins over injection in the same cycle
    wr_en = 1'b1; wr_addr = 4'd12; wr_data = 8'h11;
    inj_en = 1'b1; inj_addr = 4'd12; inj_mask = 13'h0004;
    @(negedge clk);
    wr_en = 1'b0; inj_en = 1'b0; inj_mask = '0;
    do_read(4'd12);
    chk("R9 write over injection", {rd_data, corrected, uncorr}, {8'h11, 2'b00});

    // R9: injection alone flips a data bit
    do_inject(4'd12, 13'h0200);
    do_read(4'd12);
    chk("R9 injection applied", {rd_data, corrected, uncorr}, {8'h11, 2'b10});

    // R11: read during write returns old contents
    wr_en = 1'b1; wr_addr = 4'd3; wr_data = 8'hEE;
    rd_en = 1'b1; rd_addr = 4'd3;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 old word on collision", {rd_data, corrected, uncorr}, {8'h3C, 2'b10});
    do_read(4'd3);
    chk("R11 new word after collision", {rd_data, corrected, uncorr}, {8'hEE, 2'b00});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule